// File: doc/BRIEF.md
# Port-Size Transfer Splitter

This block accepts a single bus transfer request (byte, word, longword or a 16-byte line) aimed at a memory port whose width is 8, 16 or 32 bits. It emits the port-width beats that together complete the request. Each beat carries an address, a byte count, a burst marker, an address-phase marker and a last-beat marker. The block moves to the next beat only when the current beat is acknowledged.

A burst-enable input selects how an oversized request is presented. When burst is off, the beats go out as independent single transfers, and each one has its own address phase. When burst is on, the beats form one burst with a single address phase at its start. A request that fits within the port width is always a single non-burst beat. Burst enable is expected to reset to zero, which makes splitting into single transfers the default. Data steering and acknowledge timing belong to the surrounding logic.

Top module: `xfer_port_splitter`

## Requirements
- R1: After reset, `beat_valid` is low and `req_ready` is high.
- R2: The number of beats is the request size divided by the port width when the request is larger than the port, and one otherwise. A line takes 16, 8 or 4 beats on an 8-, 16- or 32-bit port. Request size codes: 00 byte, 01 word, 10 longword, 11 line.
- R3: The first beat address equals the requested address. Each later beat address is the previous one plus the port width in bytes.
- R4: `beat_bytes` equals the smaller of the request size and the port width, in bytes.
- R5: With `burst_en` low, every beat of an oversized request has `beat_burst` low and `beat_start` high.
- R6: With `burst_en` high, every beat of an oversized request has `beat_burst` high, and `beat_start` is high on the first beat only.
- R7: A request no larger than the port width is one beat with `beat_burst` low and `beat_start` high, whatever the value of `burst_en`.
- R8: `beat_last` is high on the final beat only. One cycle after that beat is acknowledged, `beat_valid` is low and `req_ready` is high.
- R9: While `beat_ack` is low, the current beat and all of its fields hold unchanged.
- R10: Port size code 00 is 32-bit, 01 is 8-bit and 10 is 16-bit. Code 11 behaves exactly like 16-bit.
- R11: A request presented while a transfer is in progress (`req_ready` low) is ignored. It changes neither the running beats nor anything after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on this cycle |
| req_addr | input | ADDR_W | Requested start address |
| req_size | input | 2 | Request size code |
| port_size | input | 2 | Port width code |
| burst_en | input | 1 | Present oversized requests as one burst |
| beat_valid | output | 1 | A beat is being issued |
| beat_addr | output | ADDR_W | Beat address |
| beat_bytes | output | 3 | Bytes moved by this beat |
| beat_burst | output | 1 | Beat belongs to a burst |
| beat_start | output | 1 | Beat opens an address phase |
| beat_last | output | 1 | Final beat of the request |
| beat_ack | input | 1 | Current beat completed |

## Verification
The assertions assume two things about the inputs. First, `beat_ack` means something only while `beat_valid` is high. Second, `req_size`, `port_size` and `burst_en` matter only in the cycle a request is taken, so the block registers what it needs at that point. The bench drives acknowledges only while a beat is shown. It raises `req_valid` mid-transfer only in the scenario that checks the request is ignored. Every other new request is held back until `req_ready` has returned.

// File: rtl/xps_pkg.sv
package xps_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        PW_32  = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_16B = 2'b11
    } port_width_e;

    localparam int PORT_MAX_BYTES = 4;
    localparam int BYTES_W        = $clog2(PORT_MAX_BYTES) + 1;
endpackage

// File: rtl/xps_decode.sv
module xps_decode
    import xps_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int XW = $clog2(LINE_BYTES) + 1
) (
    input  logic [1:0]         req_size,
    input  logic [1:0]         port_size,
    input  logic               burst_en,
    output logic [XW-1:0]      beats_m1,
    output logic [BYTES_W-1:0] bytes_per_beat,
    output logic               burst
);
    logic [XW-1:0]      xfer_bytes;
    logic [BYTES_W-1:0] port_bytes;
    logic [1:0]         port_shift;
    logic               oversize;

    always_comb begin
        case (xfer_size_e'(req_size))
            SZ_BYTE: xfer_bytes = XW'(1);
            SZ_WORD: xfer_bytes = XW'(2);
            SZ_LONG: xfer_bytes = XW'(4);
            default: xfer_bytes = XW'(LINE_BYTES);
        endcase
        case (port_width_e'(port_size))
            PW_32:   begin port_bytes = BYTES_W'(4); port_shift = 2'd2; end
            PW_8:    begin port_bytes = BYTES_W'(1); port_shift = 2'd0; end
            default: begin port_bytes = BYTES_W'(2); port_shift = 2'd1; end
        endcase
        oversize = xfer_bytes > XW'(port_bytes);
        if (oversize) begin
            beats_m1       = (xfer_bytes >> port_shift) - XW'(1);
            bytes_per_beat = port_bytes;
        end else begin
            beats_m1       = '0;
            bytes_per_beat = xfer_bytes[BYTES_W-1:0];
        end
        burst = burst_en && oversize;
    end
endmodule

// File: rtl/xps_sequencer.sv
module xps_sequencer
    import xps_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [CNT_W-1:0]   load_beats_m1,
    input  logic [BYTES_W-1:0] load_bytes,
    input  logic               load_burst,
    input  logic               ack,
    output logic               busy,
    output logic [ADDR_W-1:0]  addr,
    output logic [BYTES_W-1:0] bytes,
    output logic               burst,
    output logic               first,
    output logic               last
);
    typedef struct packed {
        logic               busy;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   remain;
        logic [BYTES_W-1:0] bytes;
        logic               burst;
        logic               first;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy   = 1'b1;
                st_d.addr   = load_addr;
                st_d.remain = load_beats_m1;
                st_d.bytes  = load_bytes;
                st_d.burst  = load_burst;
                st_d.first  = 1'b1;
            end
        end else if (ack) begin
            if (st_q.remain == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.addr   = st_q.addr + ADDR_W'(st_q.bytes);
                st_d.remain = st_q.remain - CNT_W'(1);
                st_d.first  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign addr  = st_q.addr;
    assign bytes = st_q.bytes;
    assign burst = st_q.burst;
    assign first = st_q.first;
    assign last  = st_q.remain == '0;
endmodule

// File: rtl/xfer_port_splitter.sv
module xfer_port_splitter
    import xps_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [1:0]         port_size,
    input  logic               burst_en,
    output logic               beat_valid,
    output logic [ADDR_W-1:0]  beat_addr,
    output logic [BYTES_W-1:0] beat_bytes,
    output logic               beat_burst,
    output logic               beat_start,
    output logic               beat_last,
    input  logic               beat_ack
);
    localparam int CNT_W = $clog2(LINE_BYTES) + 1;

    logic [CNT_W-1:0]   dec_beats_m1;
    logic [BYTES_W-1:0] dec_bytes;
    logic               dec_burst;
    logic               busy, seq_burst, seq_first, seq_last;

    xps_decode #(.LINE_BYTES(LINE_BYTES)) u_decode (
        .req_size       (req_size),
        .port_size      (port_size),
        .burst_en       (burst_en),
        .beats_m1       (dec_beats_m1),
        .bytes_per_beat (dec_bytes),
        .burst          (dec_burst)
    );

    xps_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (req_valid),
        .load_addr     (req_addr),
        .load_beats_m1 (dec_beats_m1),
        .load_bytes    (dec_bytes),
        .load_burst    (dec_burst),
        .ack           (beat_ack),
        .busy          (busy),
        .addr          (beat_addr),
        .bytes         (beat_bytes),
        .burst         (seq_burst),
        .first         (seq_first),
        .last          (seq_last)
    );

    assign req_ready  = !busy;
    assign beat_valid = busy;
    assign beat_burst = busy && seq_burst;
    assign beat_start = busy && (!seq_burst || seq_first);
    assign beat_last  = busy && seq_last;
endmodule

// File: rtl/xps_checker.sv
module xps_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [2:0]        beat_bytes,
    input logic              beat_burst,
    input logic              beat_start,
    input logic              beat_last,
    input logic              beat_ack
);
    a_r9_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ack) |=> (beat_valid && $stable(beat_addr) &&
        $stable(beat_bytes) && $stable(beat_burst) && $stable(beat_last)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ack && !beat_last) |=>
        (beat_addr == $past(beat_addr) + ADDR_W'($past(beat_bytes))));

    a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ack && beat_last) |=> (!beat_valid && req_ready));

    a_r6_no_mid_start: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ack && !beat_last && beat_burst) |=>
        (beat_burst && !beat_start));

    a_r5_single_has_start: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_burst) |-> beat_start);

    a_r4_bytes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ($countones(beat_bytes) == 1));
endmodule

bind xfer_port_splitter xps_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .beat_valid (beat_valid),
    .beat_addr  (beat_addr),
    .beat_bytes (beat_bytes),
    .beat_burst (beat_burst),
    .beat_start (beat_start),
    .beat_last  (beat_last),
    .beat_ack   (beat_ack)
);

// File: tb/xfer_port_splitter_test.sv
module xfer_port_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  port_size = '0;
    logic        burst_en = 1'b0;
    logic        beat_valid;
    logic [31:0] beat_addr;
    logic [2:0]  beat_bytes;
    logic        beat_burst, beat_start, beat_last;
    logic        beat_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    xfer_port_splitter uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .port_size(port_size),
        .burst_en(burst_en), .beat_valid(beat_valid), .beat_addr(beat_addr),
        .beat_bytes(beat_bytes), .beat_burst(beat_burst), .beat_start(beat_start),
        .beat_last(beat_last), .beat_ack(beat_ack)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int size_bytes(input logic [1:0] s);
        case (s) 2'b00: return 1; 2'b01: return 2; 2'b10: return 4; default: return 16; endcase
    endfunction

    function automatic int port_bytes(input logic [1:0] p);
        case (p) 2'b00: return 4; 2'b01: return 1; default: return 2; endcase
    endfunction

    // Runs one request; stall inserts an idle ack cycle on the first beat (R9);
    // intrude presents a foreign request during the first beat (R11).
    task automatic run_xfer(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] ps,
                            input bit be, input bit stall, input bit intrude);
        int xb = size_bytes(sz);
        int pb = port_bytes(ps);
        int nb = (xb > pb) ? xb / pb : 1;                      // R2
        bit eb = be && (xb > pb);
        int eby = (xb < pb) ? xb : pb;                          // R4
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; port_size = ps; burst_en = be;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 busy", req_ready, 0);
        for (int i = 0; i < nb; i++) begin
            if (i == 0 && intrude) begin
                req_valid = 1'b1; req_addr = a ^ 32'hFFFF_0000; req_size = 2'b11;
                port_size = 2'b01; burst_en = !be;
            end
            if (i == 0 && stall) begin
                beat_ack = 1'b0;
                @(negedge clk);
                req_valid = 1'b0;
                check(beat_valid && beat_addr == a, "R9 hold", beat_addr, a);
            end
            check(beat_valid == 1'b1, "R2 valid", beat_valid, 1);
            check(beat_addr == a + 32'(i * pb), "R3 addr", beat_addr, a + 32'(i * pb));
            check(beat_bytes == 3'(eby), "R4 bytes", beat_bytes, eby);
            if (xb <= pb)
                check(!beat_burst && beat_start, "R7 single", {beat_burst, beat_start}, 1);
            else if (!eb)
                check(!beat_burst && beat_start, "R5 split", {beat_burst, beat_start}, 1);
            else
                check(beat_burst && beat_start == (i == 0), "R6 burst",
                      {beat_burst, beat_start}, {1'b1, i == 0});
            check(beat_last == (i == nb - 1), "R8 last", beat_last, i == nb - 1);
            beat_ack = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            beat_ack = 1'b0;
        end
        check(!beat_valid && req_ready, "R8 done", {beat_valid, req_ready}, 1);
        if (intrude) begin
            @(negedge clk);
            check(!beat_valid, "R11 ignored", beat_valid, 0);
        end
    endtask

    task automatic t_reset();
        check(!beat_valid && req_ready, "R1 reset", {beat_valid, req_ready}, 1);
    endtask

    task automatic t_small();                       // R7
        run_xfer(32'h0000_1003, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_2002, 2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_3000, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_split();                       // R5, R2
        run_xfer(32'h0000_4000, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0);
        run_xfer(32'h0000_5000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
        run_xfer(32'h0000_5800, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_burst();                       // R6, R2
        run_xfer(32'h0000_6000, 2'b10, 2'b01, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_6100, 2'b10, 2'b10, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_6200, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_7000, 2'b11, 2'b01, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_7100, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_port_alias();                  // R10
        run_xfer(32'h0000_8000, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_8100, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_stall();                       // R9
        run_xfer(32'h0000_9000, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_intrude();                     // R11
        run_xfer(32'h0000_A000, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small();
        t_split();
        t_burst();
        t_port_alias();
        t_stall();
        t_intrude();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule